// File: doc/BRIEF.md
# Sticky status and interrupt controller

This block keeps a word of sticky event flags next to a mask word of the same width and drives a single interrupt pin from them. Datapath logic raises individual flags with one-cycle set pulses. A host write port clears flags by writing ones and replaces the mask word. A flag stays set until the host clears it. Events set flags whether or not they are masked. The mask only decides which set flags count towards the interrupt.

The host reads the status word, with one exception. The bad-command flag reads back inverted, so that bit sits at 1 when nothing is wrong and drops to 0 when the datapath reports an unrecognised command byte.

The interrupt pin has four behaviours, selected by a two-bit mode:

| Mode | Pin behaviour |
|------|---------------|
| 00 | Level output, active low |
| 01 | Level output, active high |
| 10 | Idles high, one-clock low pulse |
| 11 | Idles low, one-clock high pulse |

In both edge modes the pulse fires when the masked OR of the flags rises. An open-drain option turns the pin into a pull-down-only output with a separate drive enable.

Top module: `stat_irq_ctrl`

## Requirements
- R1: After reset every flag and every mask bit is 0, so the status readback is 0x000001 (only the inverted bad-command bit, bit 0, shows 1) and the mask readback is 0.
- R2: A set pulse on bit i makes readback bit i show its asserted value from the next clock on, whatever the mask holds. The bit then keeps that value until it is cleared.
- R3: A status write clears every flag whose data bit is 1 and leaves every flag whose data bit is 0 unchanged. The flag is visible as cleared from the next clock.
- R4: When a set pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: Bit 0 is the bad-command flag and reads back inverted. It reads 1 when clear and reads 0 from the clock after its set pulse. A status write with data bit 0 at 1 restores it to read 1.
- R6: A mask write loads the write data into the mask word, visible on the mask readback from the next clock. Without a mask write the mask word is unchanged.
- R7: The interrupt is pending when at least one flag is set and its mask bit is 1. Flags whose mask bit is 0 never affect the pin.
- R8: In mode 00 the pin is the inverse of the pending state. In mode 01 the pin equals the pending state. In both modes the pin follows the flags and mask one clock after they change.
- R9: In mode 10 the pin idles at 1 and goes to 0 for exactly one clock when pending goes from 0 to 1. In mode 11 the pin idles at 0 and goes to 1 for exactly one clock when pending goes from 0 to 1.
- R10: With open-drain enabled, the pin value is 0 and the drive enable is 1 only while the selected behaviour calls for a low pin. With open-drain disabled, the drive enable is always 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_set_i | input | 24 | Per-bit set pulses from the datapath; bit 0 is the bad-command event |
| wr_stat_i | input | 1 | Status write strobe (write one to clear) |
| wr_mask_i | input | 1 | Mask write strobe |
| wr_data_i | input | 24 | Write data for either register |
| pin_mode_i | input | 2 | Interrupt pin behaviour: 00, 01, 10 or 11 as in R8 and R9 |
| od_en_i | input | 1 | Open-drain enable for the interrupt pin |
| stat_o | output | 24 | Status readback (bit 0 inverted) |
| mask_o | output | 24 | Mask readback |
| irq_o | output | 1 | Interrupt pin value |
| irq_oe_o | output | 1 | Interrupt pin drive enable |

## Verification
The case that is hardest to reach from the ports is a set pulse and a clearing write landing on the same bit in the same cycle while that bit is also masked in. The stimulus lines up both strobes in one cycle on purpose. It then repeats the collision in a randomised phase where the event, clear and mask words are drawn from a small pool of bits, so overlaps happen often.

The one-clock pulse of the edge modes is the other hard case. It is caught by counting pin pulses over a window that starts after a fresh pending edge.

// File: rtl/stat_irq_pkg.sv
package stat_irq_pkg;

    typedef enum logic [1:0] {
        PIN_LEVEL_LOW  = 2'b00,
        PIN_LEVEL_HIGH = 2'b01,
        PIN_EDGE_FALL  = 2'b10,
        PIN_EDGE_RISE  = 2'b11
    } pin_mode_e;

    typedef struct packed {
        logic pend;
        logic pulse;
    } pin_state_t;

endpackage

// File: rtl/stat_irq_bank.sv
module stat_irq_bank #(
    parameter int WIDTH    = 24,
    parameter int ICMD_BIT = 0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] evt_i,
    input  logic             wr_stat_i,
    input  logic             wr_mask_i,
    input  logic [WIDTH-1:0] wr_data_i,
    output logic [WIDTH-1:0] stat_o,
    output logic [WIDTH-1:0] mask_o,
    output logic             pend_o
);
    localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};
    localparam logic [WIDTH-1:0] LOW_BITS = ONE << ICMD_BIT;

    typedef struct packed {
        logic [WIDTH-1:0] flag;
        logic [WIDTH-1:0] mask;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [WIDTH-1:0] clr_w;

    assign clr_w = wr_stat_i ? wr_data_i : '0;

    // per-bit flag: set beats clear within the same cycle
    for (genvar i = 0; i < WIDTH; i++) begin : g_flag
        always_comb begin
            bank_d.flag[i] = evt_i[i] | (bank_q.flag[i] & ~clr_w[i]);
        end
    end

    always_comb begin
        bank_d.mask = wr_mask_i ? wr_data_i : bank_q.mask;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign stat_o = bank_q.flag ^ LOW_BITS;
    assign mask_o = bank_q.mask;
    assign pend_o = |(bank_q.flag & bank_q.mask);

endmodule

// File: rtl/stat_irq_pin.sv
module stat_irq_pin
    import stat_irq_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       pend_i,
    input  logic [1:0] mode_i,
    input  logic       od_en_i,
    output logic       irq_o,
    output logic       irq_oe_o
);
    pin_state_t pin_d, pin_q;
    logic       level_w;

    always_comb begin
        pin_d.pend  = pend_i;
        pin_d.pulse = pend_i & ~pin_q.pend;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pin_q <= '0;
        end else begin
            pin_q <= pin_d;
        end
    end

    always_comb begin
        unique case (pin_mode_e'(mode_i))
            PIN_LEVEL_LOW:  level_w = ~pin_q.pend;
            PIN_LEVEL_HIGH: level_w = pin_q.pend;
            PIN_EDGE_FALL:  level_w = ~pin_q.pulse;
            PIN_EDGE_RISE:  level_w = pin_q.pulse;
            default:        level_w = 1'b1;
        endcase
        if (od_en_i) begin
            irq_o    = 1'b0;
            irq_oe_o = ~level_w;
        end else begin
            irq_o    = level_w;
            irq_oe_o = 1'b1;
        end
    end

endmodule

// File: rtl/stat_irq_ctrl.sv
module stat_irq_ctrl #(
    parameter int WIDTH    = 24,
    parameter int ICMD_BIT = 0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] evt_set_i,
    input  logic             wr_stat_i,
    input  logic             wr_mask_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic [1:0]       pin_mode_i,
    input  logic             od_en_i,
    output logic [WIDTH-1:0] stat_o,
    output logic [WIDTH-1:0] mask_o,
    output logic             irq_o,
    output logic             irq_oe_o
);
    logic pend_w;

    stat_irq_bank #(
        .WIDTH    (WIDTH),
        .ICMD_BIT (ICMD_BIT)
    ) u_bank (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .evt_i     (evt_set_i),
        .wr_stat_i (wr_stat_i),
        .wr_mask_i (wr_mask_i),
        .wr_data_i (wr_data_i),
        .stat_o    (stat_o),
        .mask_o    (mask_o),
        .pend_o    (pend_w)
    );

    stat_irq_pin u_pin (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .pend_i   (pend_w),
        .mode_i   (pin_mode_i),
        .od_en_i  (od_en_i),
        .irq_o    (irq_o),
        .irq_oe_o (irq_oe_o)
    );

endmodule

// File: rtl/stat_irq_ctrl_chk.sv
module stat_irq_ctrl_chk #(
    parameter int WIDTH    = 24,
    parameter int ICMD_BIT = 0
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [WIDTH-1:0] evt_set_i,
    input logic             wr_stat_i,
    input logic             wr_mask_i,
    input logic [WIDTH-1:0] wr_data_i,
    input logic [1:0]       pin_mode_i,
    input logic             od_en_i,
    input logic [WIDTH-1:0] stat_o,
    input logic [WIDTH-1:0] mask_o,
    input logic             irq_o,
    input logic             irq_oe_o
);
    localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};
    localparam logic [WIDTH-1:0] LOW_BITS = ONE << ICMD_BIT;

    logic [WIDTH-1:0] raw_w, clr_w;
    logic             pend_w;

    assign raw_w  = stat_o ^ LOW_BITS;
    assign clr_w  = wr_stat_i ? wr_data_i : '0;
    assign pend_w = |(raw_w & mask_o);

    AST_SET_SHOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((raw_w & $past(evt_set_i)) == $past(evt_set_i))); // R2

    AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (((raw_w ^ $past(raw_w)) & ~$past(clr_w | evt_set_i)) == '0)); // R2

    AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((raw_w & $past(clr_w & ~evt_set_i)) == '0)); // R3

    AST_SET_OVER_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_stat_i && ((wr_data_i & evt_set_i) != '0))
        |=> ((raw_w & $past(wr_data_i & evt_set_i)) != '0)); // R4

    AST_ICMD_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_set_i[ICMD_BIT] |=> !stat_o[ICMD_BIT]); // R5

    AST_MASK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_mask_i |=> (mask_o == $past(wr_data_i))); // R6

    AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_mask_i |=> $stable(mask_o)); // R6

    AST_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pin_mode_i == 2'b01 && !od_en_i && !$past(pend_w)) |-> !irq_o); // R7

    AST_LEVEL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pin_mode_i == 2'b01 && !od_en_i) |-> (irq_o == $past(pend_w))); // R8

    AST_LEVEL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pin_mode_i == 2'b00 && !od_en_i) |-> (irq_o == !$past(pend_w))); // R8

    AST_EDGE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pin_mode_i == 2'b11 && !od_en_i)
        |-> (irq_o == ($past(pend_w) && !$past(pend_w, 2)))); // R9

    AST_EDGE_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pin_mode_i == 2'b10 && !od_en_i)
        |-> (irq_o == !($past(pend_w) && !$past(pend_w, 2)))); // R9

    AST_OD_NO_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        od_en_i |-> !irq_o); // R10

    AST_PUSHPULL_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !od_en_i |-> irq_oe_o); // R10

endmodule

bind stat_irq_ctrl stat_irq_ctrl_chk #(
    .WIDTH    (WIDTH),
    .ICMD_BIT (ICMD_BIT)
) u_chk (.*);

// File: tb/stat_irq_ctrl_bench.sv
module stat_irq_ctrl_bench;
    localparam int W = 24;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] evt = '0;
    logic         ws = 1'b0;
    logic         wm = 1'b0;
    logic [W-1:0] wd = '0;
    logic [1:0]   mode = 2'b00;
    logic         od = 1'b0;
    logic [W-1:0] stat_o, mask_o;
    logic         irq_o, irq_oe_o;

    int    checks = 0;
    int    fails = 0;
    int    cycles = 0;
    string cur_req = "R1";

    // behavioural reference state
    logic [W-1:0] m_flag = '0;
    logic [W-1:0] m_mask = '0;
    bit           m_pend = 0;
    bit           m_pulse = 0;

    always #4 clk = ~clk;

    stat_irq_ctrl u_stat_irq_ctrl (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .evt_set_i  (evt),
        .wr_stat_i  (ws),
        .wr_mask_i  (wm),
        .wr_data_i  (wd),
        .pin_mode_i (mode),
        .od_en_i    (od),
        .stat_o     (stat_o),
        .mask_o     (mask_o),
        .irq_o      (irq_o),
        .irq_oe_o   (irq_oe_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_flag = '0; m_mask = '0; m_pend = 0; m_pulse = 0;
        end else begin
            bit now;
            now = (m_flag & m_mask) != 0;
            m_pulse = now && !m_pend;
            m_pend = now;
            for (int i = 0; i < W; i++) begin
                if (evt[i]) m_flag[i] = 1'b1;
                else if (ws && wd[i]) m_flag[i] = 1'b0;
            end
            if (wm) m_mask = wd;
        end
    end

    function automatic bit exp_level();
        case (mode)
            2'b00:   return !m_pend;
            2'b01:   return m_pend;
            2'b10:   return !m_pulse;
            default: return m_pulse;
        endcase
    endfunction

    // every-cycle comparison against the model
    always @(negedge clk) begin
        bit lv;
        lv = exp_level();
        chk(cur_req, 32'(stat_o), 32'(m_flag ^ 24'h000001));
        chk(cur_req, 32'(mask_o), 32'(m_mask));
        chk(cur_req, 32'(irq_o), od ? 32'd0 : 32'(lv));
        chk(cur_req, 32'(irq_oe_o), od ? 32'(!lv) : 32'd1);
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic cyc(input logic [W-1:0] e, input logic s, input logic m, input logic [W-1:0] d);
        @(posedge clk);
        #1;
        evt = e; ws = s; wm = m; wd = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc('0, 1'b0, 1'b0, '0);
    endtask

    task automatic count_pulses(input logic active, output int n);
        n = 0;
        for (int i = 0; i < 6; i++) begin
            cyc('0, 1'b0, 1'b0, '0);
            @(negedge clk);
            if (irq_o == active) n++;
        end
    endtask

    initial begin
        int n;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1", 32'(stat_o), 32'h000001);
        chk("R1", 32'(mask_o), 32'h0);
        chk("R1", 32'(irq_o), 32'd1);

        cur_req = "R2";
        cyc(24'h000020, 0, 0, '0); idle(2);
        @(negedge clk);
        chk("R2", 32'(stat_o), 32'h000021);
        chk("R7", 32'(irq_o), 32'd1);

        cur_req = "R6";
        cyc('0, 0, 1, 24'h0000F0); idle(3);
        @(negedge clk);
        chk("R6", 32'(mask_o), 32'h0000F0);
        chk("R8", 32'(irq_o), 32'd0);

        cur_req = "R3";
        cyc('0, 1, 0, 24'h000000); idle(1);
        @(negedge clk);
        chk("R3", 32'(stat_o), 32'h000021);
        cyc('0, 1, 0, 24'h000020); idle(2);
        @(negedge clk);
        chk("R3", 32'(stat_o), 32'h000001);
        chk("R8", 32'(irq_o), 32'd1);

        cur_req = "R4";
        cyc(24'h000040, 1, 0, 24'h000040); idle(1);
        @(negedge clk);
        chk("R4", 32'(stat_o), 32'h000041);

        cur_req = "R5";
        cyc(24'h000001, 0, 0, '0); idle(1);
        @(negedge clk);
        chk("R5", 32'(stat_o[0]), 32'd0);
        cyc('0, 1, 0, 24'h000001); idle(1);
        @(negedge clk);
        chk("R5", 32'(stat_o[0]), 32'd1);

        cur_req = "R8";
        mode = 2'b01; idle(2);
        @(negedge clk);
        chk("R8", 32'(irq_o), 32'd1);

        cur_req = "R9";
        cyc('0, 1, 0, 24'h000040); idle(3);
        mode = 2'b11; idle(2);
        cyc(24'h000010, 0, 0, '0);
        count_pulses(1'b1, n);
        chk("R9", 32'(n), 32'd1);
        cyc('0, 1, 0, 24'h000010); idle(3);
        mode = 2'b10; idle(2);
        cyc(24'h000080, 0, 0, '0);
        count_pulses(1'b0, n);
        chk("R9", 32'(n), 32'd1);

        cur_req = "R10";
        mode = 2'b01; od = 1'b1; idle(2);
        @(negedge clk);
        chk("R10", {30'd0, irq_o, irq_oe_o}, 32'd0);
        mode = 2'b00; idle(1);
        @(negedge clk);
        chk("R10", {30'd0, irq_o, irq_oe_o}, 32'd1);
        od = 1'b0;

        cur_req = "R4";
        for (int i = 0; i < 600; i++) begin
            logic [W-1:0] pool;
            pool = 24'h0000FF;
            if (i % 50 == 0) mode = 2'($urandom);
            if (i % 97 == 0) od = ~od;
            cyc(($urandom % 4 == 0) ? (24'($urandom) & pool) : '0,
                ($urandom % 3 == 0), ($urandom % 11 == 0), 24'($urandom) & pool);
        end
        idle(3);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule